// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a chipset's 256 byte-wide configuration registers behind two neighbouring byte I/O addresses. Software first writes a register number to the even address of the pair, then reads or writes the register itself through the odd address. The stored bytes are exported side by side on one wide bus, so that the memory map decoder and other neighbours can use any field combinationally without going through the port.

Readback is sparse. Only a fixed set of register numbers returns its contents, and two identification registers return only some of their bits. Every other read through the pair yields all-ones. Writes are accepted for every register number, whether or not it can be read back. The I/O side uses single-cycle strobes with no handshake: the pair never stalls, read data is combinational, and a write takes effect at the clock edge on which its strobe is sampled. Bus arbitration and wait states belong to the surrounding bus logic.

Top module: `cfgport_top`

## Requirements
- R1: A write strobe with `io_addr` equal to `BASE_ADDR` (default 0x22, even) loads `io_wdata` into the register selector. Later data-port accesses then address that register.
- R2: A write strobe with `io_addr` equal to `BASE_ADDR+1` stores `io_wdata` into register number *selector*. From the next clock edge it appears on `cfg_regs[8*n +: 8]`, and the selector itself is not changed.
- R3: A data-port read returns the stored byte unchanged when the selector is 0x05, 0x06, any value from 0x09 to 0x13, or any value from 0x28 to 0x2A.
- R4: A data-port read with the selector at 0x04 returns the stored byte ANDed with 0x1C, so bits 7, 6, 5, 1 and 0 read as zero.
- R5: A data-port read with the selector at 0x08 returns the stored byte ANDed with 0x1F, so bits 7, 6 and 5 read as zero.
- R6: A data-port read with any other selector value returns 0xFF. A write through such a selector is still stored and exported on `cfg_regs`.
- R7: A read of the selector address, or of any address outside the pair, returns 0xFF. `io_rdata` is 0xFF whenever no read of the data port is in progress.
- R8: A write to any address outside the pair changes neither the selector nor any register.
- R9: While `rst_n` is low, the selector and all 256 registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W (16) | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, combinational |
| cfg_regs | output | 2048 | All registers; register n at bits [8n+7:8n] |

## Verification
The hardest case to reach is a register that holds a value no read can ever show: a byte written through a selector outside the readback set, or the masked-off bits of the two identification registers. The bench reaches it by writing all-ones and index-derived patterns through every one of the 256 selector values. It then compares the readback through the port with the whitelist and masks, and compares the raw bytes on the export bus against a model of what was stored. Writes to addresses that differ from the pair only in their upper bits test that decode separately from the select bit.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 8;
  localparam int NREG   = 1 << SEL_W;
  localparam int BUS_W  = BYTE_W * NREG;

  localparam logic [SEL_W-1:0] ID_A_SEL = 8'h04;
  localparam logic [SEL_W-1:0] ID_B_SEL = 8'h08;
  localparam logic [BYTE_W-1:0] ID_A_MASK = 8'h1C;
  localparam logic [BYTE_W-1:0] ID_B_MASK = 8'h1F;
  localparam logic [BYTE_W-1:0] NO_DATA   = 8'hFF;

  function automatic logic sel_readable(input logic [SEL_W-1:0] s);
    logic ok;
    ok = (s == 8'h04) || (s == 8'h05) || (s == 8'h06);
    ok = ok || ((s >= 8'h08) && (s <= 8'h13));
    ok = ok || ((s >= 8'h28) && (s <= 8'h2A));
    return ok;
  endfunction

  function automatic logic [BYTE_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
    logic [BYTE_W-1:0] m;
    if (s == ID_A_SEL)      m = ID_A_MASK;
    else if (s == ID_B_SEL) m = ID_B_MASK;
    else                    m = '1;
    return m;
  endfunction
endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0022
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              sel_we,
  output logic              dat_we,
  output logic              dat_re
);
  logic pair_hit;
  logic odd;

  assign pair_hit = (io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign odd      = io_addr[0];

  assign sel_we = io_wr & pair_hit & ~odd;
  assign dat_we = io_wr & pair_hit &  odd;
  assign dat_re = io_rd & pair_hit &  odd;
endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic              dat_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic [BUS_W-1:0]  regs_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= wdata;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    logic              hit;
    assign hit = dat_we && (sel_q == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wdata;
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/cfgport_rdmux.sv
module cfgport_rdmux
  import cfgport_pkg::*;
(
  input  logic              dat_re,
  input  logic [SEL_W-1:0]  sel_q,
  input  logic [BUS_W-1:0]  regs_flat,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] picked;
  logic [SEL_W+2:0]  base_bit;

  assign base_bit = {sel_q, 3'b000};
  assign picked   = regs_flat[base_bit +: BYTE_W];

  always_comb begin
    rdata = NO_DATA;
    if (dat_re && sel_readable(sel_q))
      rdata = picked & sel_mask(sel_q);
  end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0022
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [2047:0]     cfg_regs
);
  logic             sel_we;
  logic             dat_we;
  logic             dat_re;
  logic [SEL_W-1:0] cur_idx;

  cfgport_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .sel_we  (sel_we),
    .dat_we  (dat_we),
    .dat_re  (dat_re)
  );

  cfgport_regfile u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (sel_we),
    .dat_we    (dat_we),
    .wdata     (io_wdata),
    .sel_q     (cur_idx),
    .regs_flat (cfg_regs)
  );

  cfgport_rdmux u_rd (
    .dat_re    (dat_re),
    .sel_q     (cur_idx),
    .regs_flat (cfg_regs),
    .rdata     (io_rdata)
  );
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0022
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic [2047:0]     cfg_regs,
  input logic [7:0]        cur_idx
);
  logic [ADDR_W-1:0] odd_addr;
  logic              in_pair;
  logic [10:0]       bitpos;
  logic [7:0]        byte_at_idx;
  logic              listed;

  assign odd_addr    = BASE_ADDR + ADDR_W'(1);
  assign in_pair     = (io_addr == BASE_ADDR) || (io_addr == odd_addr);
  assign bitpos      = {cur_idx, 3'b000};
  assign byte_at_idx = cfg_regs[bitpos +: 8];
  assign listed      = (cur_idx inside {8'h04, 8'h05, 8'h06, [8'h08:8'h13], [8'h28:8'h2A]});

  p_sel_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == BASE_ADDR) |=> (cur_idx == $past(io_wdata)));

  p_data_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == odd_addr) |=> (byte_at_idx == $past(io_wdata)) && $stable(cur_idx));

  p_id_a_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == odd_addr && cur_idx == 8'h04) |-> (io_rdata[7:5] == 3'b000 && io_rdata[1:0] == 2'b00));

  p_id_b_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == odd_addr && cur_idx == 8'h08) |-> (io_rdata[7:5] == 3'b000));

  p_unlisted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == odd_addr && !listed) |-> (io_rdata == 8'hFF));

  p_sel_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != odd_addr || !io_rd) |-> (io_rdata == 8'hFF));

  p_foreign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !in_pair) |=> ($stable(cur_idx) && $stable(cfg_regs)));
endmodule

bind cfgport_top cfgport_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_addr  (io_addr),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .cfg_regs (cfg_regs),
  .cur_idx  (cur_idx)
);

// File: tb/cfgport_top_bench.sv
module cfgport_top_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   io_addr = 16'h0000;
  logic          io_wr = 1'b0;
  logic          io_rd = 1'b0;
  logic [7:0]    io_wdata = 8'h00;
  logic [7:0]    io_rdata;
  logic [2047:0] cfg_regs;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model [256];
  logic [7:0] msel;

  cfgport_top u_cfgport_top (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_regs(cfg_regs)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] expect_read(input logic [7:0] s, input logic [7:0] v);
    if (s == 8'h04) return v & 8'h1C;
    if (s == 8'h08) return v & 8'h1F;
    if (s inside {8'h05, 8'h06, [8'h09:8'h13], [8'h28:8'h2A]}) return v;
    return 8'hFF;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (a == 16'h0022) msel = d;
    else if (a == 16'h0023) model[msel] = d;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic check_export(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++)
      if (cfg_regs[i*8 +: 8] !== model[i]) begin
        if (bad == 0) begin
          n_bad++;
          $display("FAIL %s: export byte %0d actual %02h expected %02h", req, i, cfg_regs[i*8 +: 8], model[i]);
        end
        bad++;
      end
    n_cmp++;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check_export("R9 reset clears registers");
    io_read(16'h0023, d);
    check("R9 selector zero after reset (reg 0 unreadable)", d, 8'hFF);
  endtask

  task automatic t_plain();
    logic [7:0] d;
    io_write(16'h0022, 8'h05); io_write(16'h0023, 8'hA5);
    io_read(16'h0023, d); check("R1 R2 R3 reg 05", d, 8'hA5);
    io_write(16'h0022, 8'h2A); io_write(16'h0023, 8'h3C);
    io_read(16'h0023, d); check("R3 reg 2A", d, 8'h3C);
    io_write(16'h0022, 8'h13); io_write(16'h0023, 8'hC3);
    io_write(16'h0023, 8'h96);
    io_read(16'h0023, d); check("R2 R3 reg 13 rewrite keeps selector", d, 8'h96);
    io_write(16'h0022, 8'h05);
    io_read(16'h0023, d); check("R1 reselect reg 05", d, 8'hA5);
    check_export("R2 export after plain writes");
  endtask

  task automatic t_masks();
    logic [7:0] d;
    io_write(16'h0022, 8'h04); io_write(16'h0023, 8'hFF);
    io_read(16'h0023, d); check("R4 id A mask", d, 8'h1C);
    check("R4 id A stored unmasked", cfg_regs[4*8 +: 8], 8'hFF);
    io_write(16'h0022, 8'h08); io_write(16'h0023, 8'hFF);
    io_read(16'h0023, d); check("R5 id B mask", d, 8'h1F);
    io_write(16'h0023, 8'hE3);
    io_read(16'h0023, d); check("R5 id B mask pattern", d, 8'h03);
  endtask

  task automatic t_unlisted();
    logic [7:0] d;
    logic [7:0] sels [5] = '{8'h07, 8'h14, 8'h27, 8'h2B, 8'hFF};
    foreach (sels[k]) begin
      io_write(16'h0022, sels[k]); io_write(16'h0023, 8'h55 ^ sels[k]);
      io_read(16'h0023, d); check("R6 unlisted read", d, 8'hFF);
      check("R6 unlisted write stored", cfg_regs[sels[k]*8 +: 8], 8'h55 ^ sels[k]);
    end
  endtask

  task automatic t_other_reads();
    logic [7:0] d;
    io_write(16'h0022, 8'h05);
    io_read(16'h0022, d); check("R7 selector port read", d, 8'hFF);
    io_read(16'h0123, d); check("R7 upper-bit alias read", d, 8'hFF);
    io_read(16'h0021, d); check("R7 neighbour read", d, 8'hFF);
    #1 check("R7 idle rdata", io_rdata, 8'hFF);
  endtask

  task automatic t_foreign();
    logic [7:0] d;
    io_write(16'h0022, 8'h06); io_write(16'h0023, 8'h11);
    io_write(16'h0024, 8'h09); io_write(16'h0020, 8'h0A);
    io_write(16'h0122, 8'h0B); io_write(16'h0123, 8'hEE);
    io_write(16'h8023, 8'hDD);
    io_read(16'h0023, d); check("R8 foreign writes ignored", d, 8'h11);
    check_export("R8 export unchanged by foreign writes");
  endtask

  task automatic t_sweep();
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      io_write(16'h0022, 8'(i)); io_write(16'h0023, 8'(i) ^ 8'h5A);
    end
    for (int i = 0; i < 256; i++) begin
      io_write(16'h0022, 8'(i));
      io_read(16'h0023, d);
      if (d !== expect_read(8'(i), model[i])) begin
        n_bad++;
        $display("FAIL R3 R4 R5 R6 sweep sel %02h: actual %02h expected %02h", i, d, expect_read(8'(i), model[i]));
      end
      n_cmp++;
    end
    check_export("R2 R6 export after sweep");
  endtask

  task automatic t_reset_again();
    logic [7:0] d;
    io_write(16'h0022, 8'h09);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    msel = 8'h00;
    check_export("R9 mid-run reset clears registers");
    io_write(16'h0023, 8'h77);
    check("R9 selector cleared: write lands in reg 0", cfg_regs[7:0], 8'h77);
    check("R9 reg 09 still zero", cfg_regs[9*8 +: 8], 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    msel = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_masks();
    t_unlisted();
    t_other_reads();
    t_foreign();
    t_sweep();
    t_reset_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule